// File: doc/BRIEF.md
# Group-Gray Hybrid Code Adder

This block adds two numbers held in a hybrid code. The N-bit word is cut into groups of M bits. Inside each group the digit sits in reflected Gray code, so counting within a group flips a single wire per step. Between groups the carry runs with ordinary binary weight, so group k carries the weight 2^(M·k). A datapath that keeps correlated values on long wires in this code can feed them straight to the adder, with no conversion to plain binary at the edge.

The adder is purely combinational and has no clock, reset or state. It takes two hybrid operands and a carry-in. It returns the hybrid-coded sum, modulo 2^N, and a carry-out. A parameter selects one of two internal forms:
- **Group ripple (`IMPL_GROUP`).** A chain of M-bit cells. Each cell decodes its two Gray digits, adds them with the incoming carry, and re-encodes the result.
- **Wrapped binary (`IMPL_WRAP`).** The whole word is decoded group by group with XOR chains, summed in one binary adder, and re-encoded.

The two forms are interchangeable at the ports. In the house style this block has a single implicit state (combinational evaluation) and no transitions. N must be a multiple of M.

Top module: `hyb_add`

## Requirements
- R1: A word's value is the sum over groups k of digit_k·2^(M·k). Each digit_k is the Gray decode of bits [M·k+M-1 : M·k], taken as b[M-1]=g[M-1] and b[i]=b[i+1]^g[i]. Doubling a word whose only non-zero group holds Gray digit 1 gives Gray code 2'b11 in that group.
- R2: For N=4, M=2, the values 0 to 15 are coded 0000, 0001, 0011, 0010, 0100, 0101, 0111, 0110, 1100, 1101, 1111, 1110, 1000, 1001, 1011, 1010. The bits of a group are encoded as g[i]=b[i]^b[i+1], with the top bit of the group passed through unchanged.
- R3: `sum` is the hybrid encoding of (value(op_a) + value(op_b) + carry_in) mod 2^N, for every pair of operand bit patterns.
- R4: `carry_out` is 1 exactly when value(op_a) + value(op_b) + carry_in is 2^N or greater.
- R5: The least significant group of `sum` depends only on the least significant groups of the operands and on `carry_in`. Changing any higher operand group leaves it unchanged.
- R6: The largest value plus zero with carry_in=1 gives sum 0 and carry_out 1. Zero plus zero gives the code of carry_in and carry_out 0.
- R7: `IMPL_GROUP` and `IMPL_WRAP` give identical `sum` and `carry_out` for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | First operand, hybrid code |
| op_b | input | N | Second operand, hybrid code |
| carry_in | input | 1 | Carry into the least significant group |
| sum | output | N | Hybrid-coded sum modulo 2^N |
| carry_out | output | 1 | Carry out of the most significant group |

## Verification
The hardest corner is a carry crossing a group boundary. A design that passed the carry as a Gray step, rather than as binary weight, would produce sums that are off by whole groups once a digit wraps from its top code back to zero. The all-ones-value wrap with carry-in set targets carry_out: a design that dropped the final carry, or leaked it into the low group, would fail there. The low-group isolation test flips only the upper operand groups, so any backward dependency in the carry chain would show up as a changed least significant group. Running both internal forms side by side exposes a converter whose bit order is reversed in only one of them.

// File: rtl/hyb_pkg.sv
package hyb_pkg;
    typedef enum logic {
        IMPL_GROUP = 1'b0,
        IMPL_WRAP  = 1'b1
    } hyb_impl_e;
endpackage

// File: rtl/hyb_gray_conv.sv
// M-bit Gray <-> binary converter; TO_BIN picks the direction.
module hyb_gray_conv #(
    parameter int W      = 2,
    parameter bit TO_BIN = 1'b1
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (TO_BIN) begin : g_to_bin
            // prefix XOR from the top bit down
            always_comb begin
                logic acc;
                acc = din[W-1];
                dout[W-1] = acc;
                for (int i = W - 2; i >= 0; i--) begin
                    acc = acc ^ din[i];
                    dout[i] = acc;
                end
            end
        end else begin : g_to_gray
            assign dout = din ^ (din >> 1);
        end
    endgenerate
endmodule

// File: rtl/hyb_word_conv.sv
// Converts a whole word group by group.
module hyb_word_conv #(
    parameter int N      = 8,
    parameter int M      = 2,
    parameter bit TO_BIN = 1'b1
) (
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    localparam int G = N / M;
    generate
        for (genvar g = 0; g < G; g++) begin : g_grp
            hyb_gray_conv #(.W(M), .TO_BIN(TO_BIN)) u_conv (
                .din (din[g*M +: M]),
                .dout(dout[g*M +: M])
            );
        end
    endgenerate
endmodule

// File: rtl/hyb_grp_add.sv
// One M-bit group cell: Gray digits in, Gray digit and binary carry out.
module hyb_grp_add #(
    parameter int M = 2
) (
    input  logic [M-1:0] a_g,
    input  logic [M-1:0] b_g,
    input  logic         ci,
    output logic [M-1:0] s_g,
    output logic         co
);
    logic [M-1:0] a_b, b_b, s_b, chk_b;
    logic [M:0]   tot;

    hyb_gray_conv #(.W(M), .TO_BIN(1'b1)) u_dec_a (.din(a_g), .dout(a_b));
    hyb_gray_conv #(.W(M), .TO_BIN(1'b1)) u_dec_b (.din(b_g), .dout(b_b));

    assign tot = {1'b0, a_b} + {1'b0, b_b} + {{M{1'b0}}, ci};
    assign s_b = tot[M-1:0];
    assign co  = tot[M];

    hyb_gray_conv #(.W(M), .TO_BIN(1'b0)) u_enc_s (.din(s_b), .dout(s_g));

    // Round trip of the output digit through an independent decoder.
    hyb_gray_conv #(.W(M), .TO_BIN(1'b1)) u_chk (.din(s_g), .dout(chk_b));

    always_comb begin
        if (!$isunknown({a_b, b_b, ci, co, chk_b})) begin
            assert_grp_digit_R3: assert ({co, chk_b} == ({1'b0, a_b} + {1'b0, b_b} + {{M{1'b0}}, ci}))
                else $error("group digit mismatch");
        end
    end
endmodule

// File: rtl/hyb_add.sv
module hyb_add #(
    parameter int                N    = 8,
    parameter int                M    = 2,
    parameter hyb_pkg::hyb_impl_e IMPL = hyb_pkg::IMPL_GROUP
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         carry_in,
    output logic [N-1:0] sum,
    output logic         carry_out
);
    localparam int G = N / M;

    generate
        if (IMPL == hyb_pkg::IMPL_GROUP) begin : g_ripple
            logic cy [0:G];
            assign cy[0] = carry_in;
            for (genvar g = 0; g < G; g++) begin : g_cell
                hyb_grp_add #(.M(M)) u_cell (
                    .a_g(op_a[g*M +: M]),
                    .b_g(op_b[g*M +: M]),
                    .ci (cy[g]),
                    .s_g(sum[g*M +: M]),
                    .co (cy[g+1])
                );
            end
            assign carry_out = cy[G];
        end else begin : g_wrap
            logic [N-1:0] a_bin, b_bin, s_bin;
            logic [N:0]   tot;
            hyb_word_conv #(.N(N), .M(M), .TO_BIN(1'b1)) u_dec_a (.din(op_a), .dout(a_bin));
            hyb_word_conv #(.N(N), .M(M), .TO_BIN(1'b1)) u_dec_b (.din(op_b), .dout(b_bin));
            assign tot       = {1'b0, a_bin} + {1'b0, b_bin} + {{N{1'b0}}, carry_in};
            assign s_bin     = tot[N-1:0];
            assign carry_out = tot[N];
            hyb_word_conv #(.N(N), .M(M), .TO_BIN(1'b0)) u_enc_s (.din(s_bin), .dout(sum));
        end
    endgenerate

    // ---------------- checks at the ports ----------------
    function automatic logic [N:0] word_val(input logic [N-1:0] v);
        logic [N:0] r;
        r = '0;
        for (int g = 0; g < G; g++) begin
            logic acc;
            logic [N:0] dig;
            acc = 1'b0;
            dig = '0;
            for (int i = M - 1; i >= 0; i--) begin
                acc = acc ^ v[g*M + i];
                dig[i] = acc;
            end
            r = r + (dig << (g * M));
        end
        return r;
    endfunction

    function automatic logic [M-1:0] low_ref(input logic [M-1:0] a, input logic [M-1:0] b,
                                             input logic c);
        logic [M:0] ab, bb, t;
        logic acc_a, acc_b;
        ab = '0;
        bb = '0;
        acc_a = 1'b0;
        acc_b = 1'b0;
        for (int i = M - 1; i >= 0; i--) begin
            acc_a = acc_a ^ a[i];
            acc_b = acc_b ^ b[i];
            ab[i] = acc_a;
            bb[i] = acc_b;
        end
        t = ab + bb + {{M{1'b0}}, c};
        return t[M-1:0] ^ (t[M-1:0] >> 1);
    endfunction

    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in, sum, carry_out})) begin
            assert_sum_value_R3: assert (word_val(sum) ==
                    ((word_val(op_a) + word_val(op_b) + {{N{1'b0}}, carry_in}) & {1'b0, {N{1'b1}}}))
                else $error("sum value mismatch");
            assert_carry_out_R4: assert (carry_out ==
                    (((word_val(op_a) + word_val(op_b) + {{N{1'b0}}, carry_in}) >> N) != '0))
                else $error("carry_out mismatch");
            assert_low_group_R5: assert (sum[M-1:0] == low_ref(op_a[M-1:0], op_b[M-1:0], carry_in))
                else $error("low group depends on upper groups");
            if (op_a == '0 && op_b == '0) begin
                assert_zero_sum_R6: assert (sum == {{(N-1){1'b0}}, carry_in} && !carry_out)
                    else $error("zero plus zero wrong");
            end
        end
    end
endmodule

// File: tb/hyb_add_bench.sv
module hyb_add_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [3:0]  a4 = '0, b4 = '0;  logic c4 = 1'b0;
    logic [3:0]  s4, s4w;           logic co4, co4w;
    logic [7:0]  a8 = '0, b8 = '0;  logic c8 = 1'b0;
    logic [7:0]  s8;                logic co8;
    logic [15:0] a16 = '0, b16 = '0; logic c16 = 1'b0;
    logic [15:0] s16;               logic co16;

    hyb_add #(.N(4), .M(2), .IMPL(hyb_pkg::IMPL_GROUP)) u_hyb_add (
        .op_a(a4), .op_b(b4), .carry_in(c4), .sum(s4), .carry_out(co4));
    hyb_add #(.N(4), .M(2), .IMPL(hyb_pkg::IMPL_WRAP)) u_hyb_add_w4 (
        .op_a(a4), .op_b(b4), .carry_in(c4), .sum(s4w), .carry_out(co4w));
    hyb_add #(.N(8), .M(2), .IMPL(hyb_pkg::IMPL_WRAP)) u_hyb_add_8 (
        .op_a(a8), .op_b(b8), .carry_in(c8), .sum(s8), .carry_out(co8));
    hyb_add #(.N(16), .M(4), .IMPL(hyb_pkg::IMPL_GROUP)) u_hyb_add_16 (
        .op_a(a16), .op_b(b16), .carry_in(c16), .sum(s16), .carry_out(co16));

    localparam logic [3:0] CODE4 [16] = '{4'b0000, 4'b0001, 4'b0011, 4'b0010,
                                          4'b0100, 4'b0101, 4'b0111, 4'b0110,
                                          4'b1100, 4'b1101, 4'b1111, 4'b1110,
                                          4'b1000, 4'b1001, 4'b1011, 4'b1010};

    function automatic int hdec(input logic [15:0] v, input int n, input int m);
        int r = 0;
        for (int g = 0; g < n / m; g++) begin
            int dig = 0;
            int acc = 0;
            for (int i = m - 1; i >= 0; i--) begin
                acc = acc ^ int'(v[g*m + i]);
                dig = dig | (acc << i);
            end
            r = r + (dig << (g * m));
        end
        return r;
    endfunction

    function automatic logic [15:0] henc(input int val, input int n, input int m);
        logic [15:0] r = '0;
        for (int g = 0; g < n / m; g++) begin
            int dig = (val >> (g * m)) & ((1 << m) - 1);
            int gr  = dig ^ (dig >> 1);
            for (int i = 0; i < m; i++) r[g*m + i] = gr[i];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [16:0] got, input logic [16:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // expected {cout, sum} for an n-bit instance
    function automatic logic [16:0] ref_add(input logic [15:0] a, input logic [15:0] b,
                                            input logic c, input int n, input int m);
        int t = hdec(a, n, m) + hdec(b, n, m) + int'(c);
        logic [16:0] r;
        r = {1'b0, henc(t & ((1 << n) - 1), n, m)};
        r[16] = (t >= (1 << n));
        return r;
    endfunction

    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        // reset state: idle zero inputs
        step();
        chk("R3 idle 4b", {co4, 12'd0, s4}, 17'd0);
        chk("R3 idle 16b", {co16, s16}, 17'd0);
        rst_n = 1'b1;

        // R2 code table via a + 0 and a + carry_in
        for (int v = 0; v < 16; v++) begin
            @(posedge clk); a4 = CODE4[v]; b4 = '0; c4 = 1'b0;
            step(); chk("R2 identity", {co4, 12'd0, s4}, {13'd0, CODE4[v]});
            @(posedge clk); c4 = 1'b1;
            step(); chk("R2 increment", {co4, 12'd0, s4},
                        {(v == 15), 12'd0, CODE4[(v + 1) % 16]});
        end

        // R3 R4 R7 exhaustive 4-bit
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int c = 0; c < 2; c++) begin
                    @(posedge clk); a4 = 4'(a); b4 = 4'(b); c4 = 1'(c);
                    step();
                    chk("R3 R4 exhaustive", {co4, 12'd0, s4}, ref_add(16'(a), 16'(b), 1'(c), 4, 2));
                    chk("R7 impl match", {co4w, 12'd0, s4w}, {co4, 12'd0, s4});
                end

        // R1 per-group weight: digit 1 doubled gives Gray 11 in that group
        for (int g = 0; g < 4; g++) begin
            @(posedge clk); a16 = 16'(1) << (4 * g); b16 = a16; c16 = 1'b0;
            step(); chk("R1 group weight", {co16, s16}, {1'b0, 16'(3) << (4 * g)});
        end

        // R6 wrap corners
        @(posedge clk); a16 = henc(65535, 16, 4); b16 = '0; c16 = 1'b1;
        step(); chk("R6 max plus carry", {co16, s16}, {1'b1, 16'd0});
        @(posedge clk); b16 = henc(65535, 16, 4);
        step(); chk("R6 max plus max", {co16, s16}, {1'b1, henc(65535, 16, 4)});
        @(posedge clk); a16 = '0; b16 = '0; c16 = 1'b1;
        step(); chk("R6 zero plus carry", {co16, s16}, 17'd1);
        @(posedge clk); a8 = henc(255, 8, 2); b8 = '0; c8 = 1'b1;
        step(); chk("R6 max plus carry 8b", {co8, 8'd0, s8}, {1'b1, 16'd0});

        // R5 low group isolation
        for (int k = 0; k < 200; k++) begin
            logic [3:0] low_before;
            @(posedge clk); a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
            step(); low_before = s16[3:0];
            @(posedge clk); a16[15:4] = 12'($urandom); b16[15:4] = 12'($urandom);
            step(); chk("R5 low group", {13'd0, s16[3:0]}, {13'd0, low_before});
        end

        // R3 R4 random 8 and 16 bit
        for (int k = 0; k < 3000; k++) begin
            @(posedge clk);
            a8 = 8'($urandom); b8 = 8'($urandom); c8 = 1'($urandom);
            a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
            step();
            chk("R3 R4 random 8b", {co8, 8'd0, s8}, ref_add({8'd0, a8}, {8'd0, b8}, c8, 8, 2));
            chk("R3 R4 random 16b", {co16, s16}, ref_add(a16, b16, c16, 16, 4));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule